// File: doc/BRIEF.md
# Host-Side Streaming Read Pacer

This block sits on the master side of a synchronous streaming link and empties a slave device's outbound FIFO. The slave reports its occupancy only through two level flags, and each flag is valid only after a fixed delay. One flag means "nothing waiting". The other means "more than four words waiting". The pacer decides cycle by cycle whether to issue a read strobe. It uses back-to-back strobes while the large-occupancy flag is up, and single strobes separated by a hold period otherwise. Because of this, a read of an empty FIFO can never happen, even though the flags describe the FIFO as it was several cycles earlier.

The slave returns each word a fixed number of cycles after its strobe. A small shift register records which strobes are in flight. This lets the block mark exactly the cycles that carry returned data and forward those words as a local valid/data stream in strobe order. The active-low output enable is driven low from each strobe until its word has been captured, and held high at all other times.

Top module: `rd_stream_pacer`

## Requirements
- R1: When the empty flag (`lvl_empty_i` = 1) is sampled at a clock edge, `rd_o` is low in the following cycle.
- R2: While the more-than-four flag (`lvl_many_i` = 1) stays high, `rd_o` is asserted on consecutive cycles (a burst).
- R3: When the flags are sampled with `lvl_empty_i` = 0 and `lvl_many_i` = 0, exactly one single-cycle strobe is issued. After any strobe, the next rising edge of `rd_o` comes only after at least FLAG_LAT+1 strobe-free cycles, so that the flags reflect that strobe before they are polled again.
- R4: If `lvl_many_i` is low in a cycle where `rd_o` is high, `rd_o` is low in the next cycle.
- R5: For a strobe in cycle s, `rdata_i` is captured in cycle s+RD_LAT, and `out_valid_o` is high with that word in cycle s+RD_LAT+1. Strobes at the tail of a burst that has already stopped are included. There is exactly one valid beat per strobe.
- R6: When the slave's flags lag its occupancy by FLAG_LAT cycles, no strobe reaches an empty FIFO. Every pushed word is delivered in order, and no word is left unread once occupancy falls below the burst threshold.
- R7: `oe_n_o` is low in every cycle from a strobe through its capture cycle (s to s+RD_LAT) and high otherwise. Synchronous reset (`rst` = 1) gives `rd_o` = 0, `oe_n_o` = 1 and `out_valid_o` = 0 in the first cycle after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_empty_i | input | 1 | Delayed flag from the slave: outbound FIFO empty |
| lvl_many_i | input | 1 | Delayed flag from the slave: more than four words waiting |
| rd_o | output | 1 | Read strobe to the slave |
| oe_n_o | output | 1 | Output enable to the slave, active low |
| rdata_i | input | DW | Read data returned by the slave |
| out_valid_o | output | 1 | Local stream: word valid |
| out_data_o | output | DW | Local stream: word |

## Verification
The assertions check every cycle for four things. No strobe follows a sampled empty flag. A strobe never continues past a cycle where the large-occupancy flag was low. Each rise of the strobe is preceded by the full hold gap. Every valid beat is matched by an earlier strobe, with the in-flight count bounded by the read latency. Whether the FIFO is ever read while empty, and whether every word arrives in order, depends on the slave's occupancy and flag delay. Only the bench's slave model can show this, in its empty, sparse, burst, trickle and mid-burst reset scenarios. Those scenarios also show that bursts really occur and that the tail words of a stopped burst arrive.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    typedef enum logic [1:0] {
        ST_POLL   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2,
        ST_HOLD   = 2'd3
    } pace_state_e;

endpackage

// File: rtl/rsp_pace_fsm.sv
module rsp_pace_fsm
    import rsp_pkg::*;
#(
    parameter int FLAG_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_empty,
    input  logic lvl_many,
    output logic rd_strobe
);

    localparam int CW = (FLAG_LAT > 1) ? $clog2(FLAG_LAT) : 1;
    localparam logic [CW-1:0] HOLD_INIT = CW'(FLAG_LAT - 1);
    localparam int GAP_MIN = FLAG_LAT + 1;
    localparam int GW = $clog2(GAP_MIN + 1);

    typedef struct packed {
        pace_state_e   state;
        logic [CW-1:0] cnt;
        logic          rd;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    // Decision uses flags of this cycle; strobe appears next cycle.
    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.rd = 1'b0;
        unique case (fsm_q.state)
            ST_POLL: begin
                if (!lvl_empty) begin
                    fsm_d.rd    = 1'b1;
                    fsm_d.state = lvl_many ? ST_BURST : ST_SINGLE;
                end
            end
            ST_BURST: begin
                if (lvl_many) begin
                    fsm_d.rd = 1'b1;
                end else begin
                    fsm_d.state = ST_HOLD;
                    fsm_d.cnt   = HOLD_INIT;
                end
            end
            ST_SINGLE: begin
                fsm_d.state = ST_HOLD;
                fsm_d.cnt   = HOLD_INIT;
            end
            ST_HOLD: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.state = ST_POLL;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            default: fsm_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= '{state: ST_POLL, cnt: '0, rd: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_strobe = fsm_q.rd;

    // Checker state: strobe-free cycles since the last strobe (saturating).
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(GAP_MIN);
        end else if (fsm_q.rd) begin
            gap_q <= '0;
        end else if (gap_q < GW'(GAP_MIN)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_no_read_on_empty_R1: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !$past(lvl_empty));

    assert_burst_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !lvl_many) |=> !rd_strobe);

    assert_hold_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe) |-> (gap_q >= GW'(GAP_MIN)));

endmodule

// File: rtl/rsp_capture.sv
module rsp_capture #(
    parameter int DW     = 32,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_strobe,
    input  logic [DW-1:0] rdata,
    output logic          oe_n,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int IW = $clog2(RD_LAT + 3);

    typedef struct packed {
        logic [RD_LAT-1:0] tag;
        logic              vld;
        logic [DW-1:0]     data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d        = cap_q;
        cap_d.tag[0] = rd_strobe;
        for (int i = 1; i < RD_LAT; i++) begin
            cap_d.tag[i] = cap_q.tag[i-1];
        end
        cap_d.vld = cap_q.tag[RD_LAT-1];
        if (cap_q.tag[RD_LAT-1]) begin
            cap_d.data = rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign oe_n      = ~(rd_strobe | (|cap_q.tag));
    assign out_valid = cap_q.vld;
    assign out_data  = cap_q.data;

    // Checker state: strobes issued but not yet delivered.
    logic [IW-1:0] infl_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            infl_q <= '0;
        end else begin
            infl_q <= infl_q + IW'(rd_strobe) - IW'(out_valid);
        end
    end

    assert_valid_has_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (infl_q != '0));

    assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (rst)
        infl_q <= IW'(RD_LAT + 1));

    assert_capture_enabled_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(!oe_n));

endmodule

// File: rtl/rd_stream_pacer.sv
module rd_stream_pacer #(
    parameter int DW       = 32,
    parameter int FLAG_LAT = 3,
    parameter int RD_LAT   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl_empty_i,
    input  logic          lvl_many_i,
    output logic          rd_o,
    output logic          oe_n_o,
    input  logic [DW-1:0] rdata_i,
    output logic          out_valid_o,
    output logic [DW-1:0] out_data_o
);

    logic rd_strobe;

    rsp_pace_fsm #(
        .FLAG_LAT (FLAG_LAT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lvl_empty (lvl_empty_i),
        .lvl_many  (lvl_many_i),
        .rd_strobe (rd_strobe)
    );

    rsp_capture #(
        .DW     (DW),
        .RD_LAT (RD_LAT)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .rdata     (rdata_i),
        .oe_n      (oe_n_o),
        .out_valid (out_valid_o),
        .out_data  (out_data_o)
    );

    assign rd_o = rd_strobe;

    assert_reset_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_o && oe_n_o && !out_valid_o));

endmodule

// File: tb/rd_stream_pacer_tb.sv
module rd_stream_pacer_tb;

    localparam int DW = 32;
    localparam int FLAG_LAT = 3;
    localparam int RD_LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fl_empty, fl_many;
    logic          rd_o, oe_n_o, out_valid_o;
    logic [DW-1:0] rdata, out_data_o;

    always #10 clk = ~clk;

    rd_stream_pacer #(.DW(DW), .FLAG_LAT(FLAG_LAT), .RD_LAT(RD_LAT)) u_dut (
        .clk (clk), .rst (rst),
        .lvl_empty_i (fl_empty), .lvl_many_i (fl_many),
        .rd_o (rd_o), .oe_n_o (oe_n_o), .rdata_i (rdata),
        .out_valid_o (out_valid_o), .out_data_o (out_data_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- slave model: FIFO, lagging flags, 2-cycle read data
    logic [DW-1:0] mem [256];
    logic [7:0]    wp, rp;
    int            cnt;
    logic          push_v = 1'b0;
    logic [DW-1:0] push_w = '0;
    logic [DW-1:0] d1;
    logic          e0, e1, m0, m1;
    int            uflow;

    always @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= 0;
            d1 <= '0; rdata <= '0;
            e0 <= 1'b1; e1 <= 1'b1; fl_empty <= 1'b1;
            m0 <= 1'b0; m1 <= 1'b0; fl_many <= 1'b0;
        end else begin
            if (rd_o && cnt == 0) uflow++;
            d1    <= (rd_o && cnt > 0) ? mem[rp] : 32'hDEAD_BEEF;
            rdata <= d1;
            if (push_v) begin
                mem[wp] <= push_w;
                wp <= wp + 1'b1;
            end
            if (rd_o && cnt > 0) rp <= rp + 1'b1;
            cnt <= cnt + (push_v ? 1 : 0) - ((rd_o && cnt > 0) ? 1 : 0);
            e0 <= (cnt == 0); e1 <= e0; fl_empty <= e1;
            m0 <= (cnt > 4);  m1 <= m0; fl_many  <= m1;
        end
    end

    // ---------------- monitor, sampled at negedge
    logic [DW-1:0] tx [256];
    logic [DW-1:0] rx [256];
    int tx_n, rx_n;
    int n_strobe, run, max_run, idle_run, seen_strobe;
    int empty_viol, stop_viol, gap_viol, oe_viol, valid_viol, stop_events;
    logic h1, h2, h3, p_empty, p_many;

    task automatic clear_stats();
        tx_n = 0; rx_n = 0; uflow = 0;
        n_strobe = 0; run = 0; max_run = 0;
        empty_viol = 0; stop_viol = 0; gap_viol = 0;
        oe_viol = 0; valid_viol = 0; stop_events = 0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            h1 = 0; h2 = 0; h3 = 0; p_empty = 1; p_many = 0;
            idle_run = 0; seen_strobe = 0; run = 0;
        end else begin
            if (rd_o) begin
                n_strobe++; run++;
                if (run > max_run) max_run = run;
                if (!h1 && seen_strobe != 0 && idle_run < FLAG_LAT + 1) gap_viol++;   // R3
                if (p_empty) empty_viol++;                                               // R1
                if (h1 && !p_many) stop_viol++;                                          // R4
                seen_strobe = 1; idle_run = 0;
            end else begin
                run = 0; idle_run++;
                if (h1 && !p_many) stop_events++;
            end
            if (oe_n_o !== !(rd_o || h1 || h2)) oe_viol++;                               // R7
            if (out_valid_o !== h3) valid_viol++;                                        // R5
            if (out_valid_o) begin
                rx[rx_n[7:0]] = out_data_o;
                rx_n++;
            end
            h3 = h2; h2 = h1; h1 = rd_o;
            p_empty = fl_empty; p_many = fl_many;
        end
    end

    // ---------------- stimulus helpers
    task automatic push_words(input int n, input int spacing, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_v = 1'b1;
            push_w = base + DW'(i);
            tx[tx_n[7:0]] = push_w;
            tx_n++;
            for (int k = 1; k < spacing; k++) begin
                @(negedge clk);
                push_v = 1'b0;
            end
        end
        @(negedge clk);
        push_v = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 2000 && rx_n < tx_n; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        int bad;
        bad = 0;
        check(rx_n == tx_n, req, rx_n, tx_n);
        for (int i = 0; i < tx_n && i < rx_n; i++)
            if (rx[i] !== tx[i]) bad++;
        check(bad == 0, req, bad, 0);
        check(uflow == 0, "R6 underflow", uflow, 0);
    endtask

    // ---------------- scenarios
    task automatic t_reset();
        @(negedge clk);
        check(rd_o == 1'b0, "R7 reset rd", rd_o, 0);
        check(oe_n_o == 1'b1, "R7 reset oe_n", oe_n_o, 1);
        check(out_valid_o == 1'b0, "R7 reset valid", out_valid_o, 0);
    endtask

    task automatic t_empty();
        clear_stats();
        repeat (40) @(negedge clk);
        check(n_strobe == 0, "R1 no strobe on empty", n_strobe, 0);
    endtask

    task automatic t_sparse();
        clear_stats();
        push_words(3, 1, 32'hA000_0000);
        wait_drain();
        check_stream("R5 sparse");
        check(max_run == 1, "R3 single strobes only", max_run, 1);
        check(gap_viol == 0, "R3 hold gap", gap_viol, 0);
    endtask

    task automatic t_burst();
        clear_stats();
        push_words(24, 1, 32'hB000_0000);
        wait_drain();
        check_stream("R6 burst drain");
        check(max_run >= 8, "R2 back-to-back strobes", max_run, 8);
        check(stop_events > 0, "R4 burst stop seen", stop_events, 1);
        check(stop_viol == 0, "R4 strobe low after drop", stop_viol, 0);
        check(gap_viol == 0, "R3 hold gap after burst", gap_viol, 0);
        check(valid_viol == 0, "R5 valid timing incl. tail", valid_viol, 0);
        check(oe_viol == 0, "R7 oe window", oe_viol, 0);
        check(empty_viol == 0, "R1 no strobe after empty", empty_viol, 0);
    endtask

    task automatic t_trickle();
        clear_stats();
        push_words(10, 5, 32'hC000_0000);
        wait_drain();
        check_stream("R6 trickle");
        check(valid_viol == 0, "R5 valid timing trickle", valid_viol, 0);
        check(oe_viol == 0, "R7 oe trickle", oe_viol, 0);
    endtask

    task automatic t_midreset();
        clear_stats();
        push_words(20, 1, 32'hD000_0000);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_o == 1'b0, "R7 mid reset rd", rd_o, 0);
        check(oe_n_o == 1'b1, "R7 mid reset oe_n", oe_n_o, 1);
        check(out_valid_o == 1'b0, "R7 mid reset valid", out_valid_o, 0);
        clear_stats();
        push_words(6, 2, 32'hE000_0000);
        wait_drain();
        check_stream("R6 after reset");
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_stats();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty();
        t_sparse();
        t_burst();
        t_trickle();
        t_midreset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule